// File: doc/BRIEF.md
# Prescaled Compare Timer

A free-running up-counter driven by a software-controlled run flag, with a power-of-two clock divider ahead of it and a bank of compare channels behind it. Software programs the count width, the divider exponent and one compare value per channel over a simple word-addressed 32-bit register port. It then starts, stops or zeroes the counter by writing single-cycle task registers.

Each compare channel watches every value the counter steps onto. When the counter lands on the channel's compare value, truncated to the active width, the channel sets a sticky event flag. The flag stays set until software writes zero to it. A compare value below the current count is therefore reached only after the counter wraps at the selected width. The interrupt output combines the event flags through a per-channel enable mask, which has separate set and clear registers.

The register port is word addressed: `addr_i` selects a 32-bit register. A write happens in a cycle with `req_i` and `we_i` high. Read data is combinational and is valid in a cycle with `req_i` high and `we_i` low.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count (read at word 0x03), every event flag, the enable mask, the width code (word 0x04), the divider exponent (word 0x05) and `irq_o` are all 0.
- R2: Writing data with bit 0 set to word 0x00 starts counting, to word 0x01 stops it, and to word 0x02 zeroes the counter and the divider. A stopped counter holds its value.
- R3: While running, the counter advances once every 2^P clocks, where P is the divider exponent. P = 0 advances every clock. A write of a value above 9 to word 0x05 stores 9.
- R4: Width code (word 0x04, bits 1:0) is decoded as 0 = 16 bits, 1 = 8 bits, 2 = 24 bits and 3 = 32 bits. The counter wraps from the all-ones value of the selected width to 0.
- R5: The event flag of channel i (word 0x10+i, bit 0) is set in the clock edge at which the counter steps onto compare value i (word 0x18+i), masked to the active width. Every value passed while running is seen.
- R6: An event flag stays set until a write of 0 to its word clears it. A write of any nonzero value to that word has no effect.
- R7: A compare value below the current count does not fire until the counter has wrapped.
- R8: `irq_o` is high when any event flag is set and its enable bit is also set. Writing to word 0x08 sets enable bits and writing to word 0x09 clears enable bits, with bit i for channel i. Both words read back the enable mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Enabled-event interrupt |

## Verification
The bench builds the block with its defaults: four channels and a divider ceiling of 9. At the 16-bit width with exponent 0, a full wrap takes 65536 clocks. This puts the compare-after-wrap case of R7 well within the run, and the 8-bit width wraps in a few hundred clocks. The exponent ceiling of 9 is short enough that a divided count of several ticks can be checked exactly. Wraps at 24 and 32 bits lie out of reach, so for those widths only the decode is exercised through the assertions.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned CNT_W  = 32;

  typedef enum logic [1:0] {
    W16 = 2'd0,
    W8  = 2'd1,
    W24 = 2'd2,
    W32 = 2'd3
  } width_e;

  localparam logic [ADDR_W-1:0] A_START    = 6'h00;
  localparam logic [ADDR_W-1:0] A_STOP     = 6'h01;
  localparam logic [ADDR_W-1:0] A_CLEAR    = 6'h02;
  localparam logic [ADDR_W-1:0] A_COUNT    = 6'h03;
  localparam logic [ADDR_W-1:0] A_WIDTH    = 6'h04;
  localparam logic [ADDR_W-1:0] A_PRESC    = 6'h05;
  localparam logic [ADDR_W-1:0] A_IEN_SET  = 6'h08;
  localparam logic [ADDR_W-1:0] A_IEN_CLR  = 6'h09;
  localparam logic [ADDR_W-1:0] A_EVT_BASE = 6'h10;
  localparam logic [ADDR_W-1:0] A_CC_BASE  = 6'h18;

  function automatic logic [CNT_W-1:0] width_mask(width_e w);
    case (w)
      W8:      return 32'h0000_00FF;
      W16:     return 32'h0000_FFFF;
      W24:     return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int unsigned PRE_MAX = 9,
  localparam int unsigned DIV_W = (PRE_MAX > 0) ? PRE_MAX : 1,
  localparam int unsigned PRE_W = $clog2(PRE_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] mask;

  assign span   = {{DIV_W{1'b0}}, 1'b1} << presc_i;
  assign mask   = DIV_W'(span - 1'b1);
  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clear_i) div_q <= '0;
    else if (run_i)   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
  import ptmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic             run_o,
  output logic             step_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign nxt_o  = (cnt_q + 1'b1) & mask_i;
  assign step_o = tick_i && !clear_i;
  assign run_o  = run_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
    else if (stop_i)  run_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= nxt_o;
  end
endmodule

// File: rtl/ptmr_compare.sv
module ptmr_compare
  import ptmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         step_i,
  input  logic [CNT_W-1:0]             nxt_i,
  input  logic [CNT_W-1:0]             mask_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cc_i,
  input  logic [NUM_CH-1:0]            clr_i,
  output logic [NUM_CH-1:0]            evt_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    logic evt_q;
    assign hit = step_i && (nxt_i == (cc_i[i] & mask_i));
    // a hit in the same cycle as a software clear wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       evt_q <= 1'b0;
      else if (hit)      evt_q <= 1'b1;
      else if (clr_i[i]) evt_q <= 1'b0;
    end
    assign evt_o[i] = evt_q;
  end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned PRE_MAX = 9,
  localparam int unsigned PRE_W = $clog2(PRE_MAX + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic [NUM_CH-1:0]            evt_i,
  output logic                         start_o,
  output logic                         stop_o,
  output logic                         clear_o,
  output width_e                       width_o,
  output logic [PRE_W-1:0]             presc_o,
  output logic [NUM_CH-1:0]            ien_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] cc_o,
  output logic [NUM_CH-1:0]            evt_clr_o
);
  logic                         wr;
  width_e                       width_q;
  logic [PRE_W-1:0]             presc_q;
  logic [NUM_CH-1:0]            ien_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cc_q;

  assign wr      = req_i && we_i;
  assign start_o = wr && (addr_i == A_START) && wdata_i[0];
  assign stop_o  = wr && (addr_i == A_STOP)  && wdata_i[0];
  assign clear_o = wr && (addr_i == A_CLEAR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= W16;
      presc_q <= '0;
      ien_q   <= '0;
    end else if (wr) begin
      case (addr_i)
        A_WIDTH:   width_q <= width_e'(wdata_i[1:0]);
        A_PRESC:   presc_q <= (wdata_i > 32'(PRE_MAX)) ? PRE_W'(PRE_MAX)
                                                        : wdata_i[PRE_W-1:0];
        A_IEN_SET: ien_q   <= ien_q | wdata_i[NUM_CH-1:0];
        A_IEN_CLR: ien_q   <= ien_q & ~wdata_i[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel_cc;
    assign sel_cc = wr && (addr_i == A_CC_BASE + ADDR_W'(i));
    assign evt_clr_o[i] = wr && (addr_i == A_EVT_BASE + ADDR_W'(i)) && (wdata_i == '0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cc_q[i] <= '0;
      else if (sel_cc) cc_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        A_COUNT:              rdata_o = cnt_i;
        A_WIDTH:              rdata_o = 32'(width_q);
        A_PRESC:              rdata_o = 32'(presc_q);
        A_IEN_SET, A_IEN_CLR: rdata_o = 32'(ien_q);
        default: ;
      endcase
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr_i == A_EVT_BASE + ADDR_W'(i)) rdata_o = {31'b0, evt_i[i]};
        if (addr_i == A_CC_BASE + ADDR_W'(i))  rdata_o = cc_q[i];
      end
    end
  end

  assign width_o = width_q;
  assign presc_o = presc_q;
  assign ien_o   = ien_q;
  assign cc_o    = cc_q;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned PRE_MAX = 9,
  localparam int unsigned PRE_W = $clog2(PRE_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  logic                         start, stop, clear, tick, run, step;
  width_e                       width;
  logic [PRE_W-1:0]             presc;
  logic [NUM_CH-1:0]            ien, evt, evt_clr;
  logic [NUM_CH-1:0][CNT_W-1:0] cc;
  logic [CNT_W-1:0]             cnt, nxt, cnt_mask;

  assign cnt_mask = width_mask(width);

  ptmr_regs #(.NUM_CH(NUM_CH), .PRE_MAX(PRE_MAX)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .evt_i(evt),
    .start_o(start), .stop_o(stop), .clear_o(clear),
    .width_o(width), .presc_o(presc), .ien_o(ien), .cc_o(cc),
    .evt_clr_o(evt_clr)
  );

  ptmr_prescaler #(.PRE_MAX(PRE_MAX)) u_presc (
    .clk_i, .rst_ni, .run_i(run), .clear_i(clear), .presc_i(presc), .tick_o(tick)
  );

  ptmr_counter u_cnt (
    .clk_i, .rst_ni, .start_i(start), .stop_i(stop), .clear_i(clear),
    .tick_i(tick), .mask_i(cnt_mask), .run_o(run), .step_o(step),
    .nxt_o(nxt), .cnt_o(cnt)
  );

  ptmr_compare #(.NUM_CH(NUM_CH)) u_cmp (
    .clk_i, .rst_ni, .step_i(step), .nxt_i(nxt), .mask_i(cnt_mask),
    .cc_i(cc), .clr_i(evt_clr), .evt_o(evt)
  );

  assign irq_o = |(evt & ien);
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
  import ptmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_i,
  input logic                         we_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [31:0]                  wdata_i,
  input logic                         irq_o,
  input logic [CNT_W-1:0]             cnt_i,
  input logic [CNT_W-1:0]             mask_i,
  input logic [NUM_CH-1:0]            evt_i,
  input logic [NUM_CH-1:0]            ien_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] cc_i
);
  logic wr_start, wr_stop, wr_clear;
  assign wr_start = req_i && we_i && addr_i == A_START && wdata_i[0];
  assign wr_stop  = req_i && we_i && addr_i == A_STOP  && wdata_i[0];
  assign wr_clear = req_i && we_i && addr_i == A_CLEAR && wdata_i[0];

  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clear |=> cnt_i == '0);

  a_r2_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stop ##1 !(wr_start || wr_clear) |=> $stable(cnt_i));

  a_r4_step_or_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_i) |-> (cnt_i == '0) || (cnt_i == (($past(cnt_i) + 1'b1) & $past(mask_i))));

  a_r8_no_irq_unenabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == '0) |-> !irq_o);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    a_r5_set_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_i[i]) |-> cnt_i == ($past(cc_i[i]) & $past(mask_i)));

    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] && !(req_i && we_i && addr_i == A_EVT_BASE + ADDR_W'(i) && wdata_i == '0)
      |=> evt_i[i]);
  end
endmodule

bind prescaled_timer ptmr_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .cnt_i(cnt), .mask_i(cnt_mask),
  .evt_i(evt), .ien_i(ien), .cc_i(cc)
);

// File: tb/prescaled_timer_tb.sv
module prescaled_timer_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        irq_probe = 1'b0;
  bit          done = 1'b0;

  int n_cmp = 0, n_bad = 0;

  string       q_tag[$];
  logic [31:0] q_exp[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  prescaled_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pops one expected item per observed read or irq probe
  always @(negedge clk) begin
    if ((req && !we) || irq_probe) begin
      logic [31:0] act;
      string       tag;
      logic [31:0] exp;
      act = irq_probe ? {31'b0, irq} : rdata;
      if (q_exp.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: result with no expected item, actual %0h", act);
      end else begin
        tag = q_tag.pop_front();
        exp = q_exp.pop_front();
        n_cmp++;
        if (act !== exp) begin
          n_bad++;
          $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_expect(input string tag, input logic [5:0] a, input logic [31:0] e);
    q_tag.push_back(tag); q_exp.push_back(e);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic irq_expect(input string tag, input logic e);
    q_tag.push_back(tag); q_exp.push_back({31'b0, e});
    irq_probe = 1'b1;
    @(posedge clk); #1;
    irq_probe = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  // start, k idle clocks, stop: k+1 counting edges
  task automatic run_for(input int k);
    wr(6'h00, 32'h1);
    idle(k);
    wr(6'h01, 32'h1);
  endtask

  task automatic expect_events(input string tag, input logic [3:0] e);
    for (int i = 0; i < 4; i++) rd_expect(tag, 6'h10 + 6'(i), {31'b0, e[i]});
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd_expect("R1 count", 6'h03, 0);
    rd_expect("R1 width", 6'h04, 0);
    rd_expect("R1 presc", 6'h05, 0);
    rd_expect("R1 ien", 6'h08, 0);
    expect_events("R1 events", 4'b0000);
    irq_expect("R1 irq", 1'b0);

    // 16-bit, full rate
    wr(6'h18, 2); wr(6'h19, 162); wr(6'h1A, 480); wr(6'h1B, 32'h8000);
    run_for(99);
    rd_expect("R2 R3 count after 100 clocks", 6'h03, 100);
    expect_events("R5 first lap", 4'b0001);
    wr(6'h1B, 50);
    run_for(499);
    rd_expect("R2 count 600", 6'h03, 600);
    expect_events("R7 below-count compare not yet", 4'b0111);
    run_for(64995);
    rd_expect("R4 16-bit wrap", 6'h03, 60);
    expect_events("R7 fired after wrap", 4'b1111);

    // R6 stickiness
    wr(6'h10, 5);
    rd_expect("R6 nonzero write ignored", 6'h10, 1);
    for (int i = 0; i < 4; i++) wr(6'h10 + 6'(i), 0);
    expect_events("R6 cleared", 4'b0000);

    // R8 enables
    wr(6'h08, 32'h5);
    rd_expect("R8 ien set", 6'h09, 32'h5);
    irq_expect("R8 no event no irq", 1'b0);

    // 8-bit mode
    wr(6'h04, 1);
    wr(6'h02, 1);
    rd_expect("R2 clear", 6'h03, 0);
    wr(6'h18, 32'h10A); wr(6'h19, 32'h30);
    run_for(299);
    rd_expect("R4 8-bit wrap", 6'h03, 44);
    expect_events("R5 masked compare", 4'b1111);
    irq_expect("R8 enabled event", 1'b1);
    wr(6'h09, 32'h1);
    rd_expect("R8 ien clr", 6'h08, 32'h4);
    irq_expect("R8 ch2 still enabled", 1'b1);
    wr(6'h09, 32'h4);
    irq_expect("R8 all disabled", 1'b0);
    idle(20);
    rd_expect("R2 stopped holds", 6'h03, 44);

    // R3 prescaler, 32-bit
    wr(6'h04, 3);
    wr(6'h05, 2);
    rd_expect("R3 presc readback", 6'h05, 2);
    wr(6'h02, 1);
    run_for(39);
    rd_expect("R3 divide by 4", 6'h03, 10);
    wr(6'h05, 12);
    rd_expect("R3 clamp to 9", 6'h05, 9);
    wr(6'h02, 1);
    run_for(1535);
    rd_expect("R3 divide by 512", 6'h03, 3);

    idle(2);
    if (q_exp.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: %0d items never observed, expected 0", q_exp.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule